// File: doc/BRIEF.md
# Interrupt vector byte generator

This block gathers interrupt requests from one raster source and three DMA channels and presents them to a Z80-style CPU as one active-low interrupt line. When the CPU acknowledges the interrupt (M1 and IORQ both low), the block drives one 8-bit vector byte. The low three bits name the serviced source. The upper five bits come from a software-written register. In interrupt mode 0 the CPU executes this byte as an opcode. In mode 2 it uses the byte as a table index.

Software works through a small write-only port with three selects. Select 0 loads the five upper vector bits and the auto-clear flag. Select 1 loads the enhanced-mode flag and the per-source enable mask. Select 2 is a write-one-to-clear strobe for pending requests. Each source has a clear output that pulses for one cycle whenever its pending request is dropped. A source can use this pulse to rearm.

Source indices used throughout: 0 = raster, 1 = DMA channel 0, 2 = DMA channel 1, 3 = DMA channel 2.

Top module: `irq_vector_gen`

## Requirements
- R1: After synchronous reset, `irq_n` is 1, `data_oe` is 0, `clr_out` is 0, all sources are masked, enhanced mode is off and auto-clear is off.
- R2: A pulse on `req_in[i]` while source i is enabled latches a pending request. `irq_n` is 0 from the second rising edge after the pulse. It stays 0 as long as any enabled request is pending.
- R3: The vector byte is {base[4:0], code}. Base is loaded from write-data bits 7..3 on select 0. The code is 6 for raster, 4 for DMA channel 0, 2 for DMA channel 1 and 0 for DMA channel 2.
- R4: Among enabled pending requests, raster has the highest priority, then DMA channel 0, then DMA channel 1, then DMA channel 2. The byte is frozen while the acknowledge is held. With nothing pending, the raster code is presented.
- R5: When write-data bit 0 on select 0 is 1 (auto-clear), the first cycle of an acknowledge clears the serviced request. The matching `clr_out` bit pulses for one cycle. `irq_n` returns to 1 if nothing else is pending.
- R6: With auto-clear off, an acknowledge leaves the request pending. A select-2 write clears each source whose write-data bit (bits 3..0, by source index) is 1, and pulses the matching `clr_out` bits.
- R7: When the enhanced flag (select 1, write-data bit 7) is 0, the byte driven during acknowledge is 0x00.
- R8: The byte driven during acknowledge is never 0xFF.
- R9: `data_oe` is 1 only while `m1_n` and `iorq_n` are both 0. An opcode fetch (only `m1_n` low) or an I/O cycle (only `iorq_n` low) never drives the bus and never services a request.
- R10: A request on a source whose enable bit (select 1, write-data bits 3..0 by source index) is 0 is not latched. It does not assert `irq_n`, even after the source is enabled later.
- R11: If a request for a source arrives in the same cycle that its pending request is cleared, the new request survives. The clear pulse is still sent.
- R12: The vector is taken from the pending state before the acknowledge starts. A DMA request pending at that point is vectored even if a raster request arrives during the acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 vector, 1 control, 2 clear |
| reg_wdata | input | 8 | Register write data |
| req_in | input | 4 | Request pulses by source index |
| clr_out | output | 4 | One-cycle clear pulses by source index |
| irq_n | output | 1 | Interrupt request to the CPU, active low |
| m1_n | input | 1 | CPU M1, active low |
| iorq_n | input | 1 | CPU IORQ, active low |
| data_out | output | 8 | Vector byte |
| data_oe | output | 1 | Data bus drive enable |

## Verification
Two functions can fall in the same cycle: a request can be latched while an acknowledge auto-clears that source, and a request can arrive while the vector is being frozen at the start of an acknowledge. The bench creates the first case by pulsing the raster request on the opening cycle of an acknowledge that services the raster source. It then expects both a clear pulse and an interrupt line that stays low. It creates the second case by raising the raster request together with an acknowledge of a pending DMA request, and expects the DMA byte. A behavioural model is compared with the outputs on every clock.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

  typedef enum logic [1:0] {
    SEL_VEC  = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_CLR  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // Source code placed in the low vector bits: highest index gets code 0,
  // each lower index two more, so bit 0 of the code is always zero.
  function automatic int src_code(input int idx, input int nsrc);
    return 2 * (nsrc - 1 - idx);
  endfunction

endpackage

// File: rtl/irqv_regs.sv
module irqv_regs #(
  parameter int DATA_W = 8,
  parameter int CODE_W = 3,
  parameter int NSRC   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-CODE_W-1:0] base,
  output logic              auto_clr,
  output logic              enh,
  output logic [NSRC-1:0]   mask,
  output logic [NSRC-1:0]   clr_wr
);
  import irqv_pkg::*;

  localparam int BASE_W = DATA_W - CODE_W;

  logic unused_wbits;
  assign unused_wbits = ^wdata[CODE_W-1:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      base     <= '0;
      auto_clr <= 1'b0;
      enh      <= 1'b0;
      mask     <= '0;
    end else if (wr) begin
      if (sel == SEL_VEC) begin
        base     <= wdata[DATA_W-1 -: BASE_W];
        auto_clr <= wdata[0];
      end
      if (sel == SEL_CTRL) begin
        enh  <= wdata[DATA_W-1];
        mask <= wdata[NSRC-1:0];
      end
    end
  end

  assign clr_wr = (wr && sel == SEL_CLR) ? wdata[NSRC-1:0] : '0;

endmodule

// File: rtl/irqv_pending.sv
module irqv_pending #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] pend_o
);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst)
        pend_o[g] <= 1'b0;
      else if (set_i[g])
        pend_o[g] <= 1'b1;
      else if (clr_i[g])
        pend_o[g] <= 1'b0;
    end

    p_set_wins_r11: assert property (@(posedge clk) disable iff (rst)
      set_i[g] |=> pend_o[g]);

    p_clear_r6: assert property (@(posedge clk) disable iff (rst)
      (clr_i[g] && !set_i[g]) |=> !pend_o[g]);
  end

endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter #(
  parameter int NSRC  = 4,
  parameter int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]  act_i,
  output logic             vld_o,
  output logic [IDX_W-1:0] idx_o
);

  // Lowest index wins; scanning from the top lets lower indices overwrite.
  always_comb begin
    idx_o = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (act_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign vld_o = |act_i;

endmodule

// File: rtl/irq_vector_gen.sv
module irq_vector_gen #(
  parameter int DATA_W = 8,
  parameter int CODE_W = 3,
  parameter int NSRC   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [NSRC-1:0]   req_in,
  output logic [NSRC-1:0]   clr_out,
  output logic              irq_n,
  input  logic              m1_n,
  input  logic              iorq_n,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe
);
  import irqv_pkg::*;

  localparam int BASE_W = DATA_W - CODE_W;
  localparam int IDX_W  = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [BASE_W-1:0] base;
  logic              auto_clr, enh;
  logic [NSRC-1:0]   mask, clr_wr, pend, act, set_m, svc_clr, clr_all;
  logic              arb_vld, vld_q, ack, ack_q, ack_start;
  logic [IDX_W-1:0]  arb_idx, src_q;
  logic [DATA_W-1:0] vec_q;
  logic [CODE_W-1:0] code_tbl [NSRC];

  for (genvar g = 0; g < NSRC; g++) begin : g_code
    assign code_tbl[g] = CODE_W'(src_code(g, NSRC));
  end

  irqv_regs #(.DATA_W(DATA_W), .CODE_W(CODE_W), .NSRC(NSRC)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
    .base(base), .auto_clr(auto_clr), .enh(enh), .mask(mask), .clr_wr(clr_wr)
  );

  irqv_pending #(.NSRC(NSRC)) u_pend (
    .clk(clk), .rst(rst), .set_i(set_m), .clr_i(clr_all), .pend_o(pend)
  );

  irqv_arbiter #(.NSRC(NSRC), .IDX_W(IDX_W)) u_arb (
    .act_i(act), .vld_o(arb_vld), .idx_o(arb_idx)
  );

  assign ack       = !m1_n && !iorq_n;
  assign ack_start = ack && !ack_q;
  assign act       = pend & mask;
  assign set_m     = req_in & mask;
  assign svc_clr   = (ack_start && auto_clr && vld_q) ? (NSRC'(1) << src_q) : '0;
  assign clr_all   = clr_wr | svc_clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q   <= 1'b0;
      clr_out <= '0;
      irq_n   <= 1'b1;
      vld_q   <= 1'b0;
      src_q   <= '0;
      vec_q   <= '0;
    end else begin
      ack_q   <= ack;
      clr_out <= clr_all;
      irq_n   <= ~(|act);
      if (!ack) begin
        vld_q <= arb_vld;
        src_q <= arb_idx;
        vec_q <= enh ? {base, code_tbl[arb_idx]} : '0;
      end
    end
  end

  assign data_out = vec_q;
  assign data_oe  = ack;

  p_irq_follow_r2: assert property (@(posedge clk) disable iff (rst)
    (|act) |=> !irq_n);

  p_vec_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (ack && ack_q) |-> $stable(vec_q));

  p_autoclr_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    (ack_start && auto_clr && vld_q) |=> (clr_out != '0));

  p_enh_off_r7: assert property (@(posedge clk) disable iff (rst)
    (!enh && !ack) |=> (vec_q == '0));

  p_never_ff_r8: assert property (@(posedge clk) disable iff (rst)
    data_oe |-> (data_out != '1));

endmodule

// File: tb/irq_vector_gen_test.sv
module irq_vector_gen_test;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_sel = 2'd3;
  logic [7:0] reg_wdata = 8'h00;
  logic [3:0] req_in = 4'h0;
  logic       m1_n = 1'b1;
  logic       iorq_n = 1'b1;
  logic [3:0] clr_out;
  logic       irq_n;
  logic [7:0] data_out;
  logic       data_oe;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  irq_vector_gen uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .req_in(req_in), .clr_out(clr_out),
    .irq_n(irq_n), .m1_n(m1_n), .iorq_n(iorq_n),
    .data_out(data_out), .data_oe(data_oe)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural reference model
  bit [3:0] m_pend, m_mask, m_clr;
  bit [4:0] m_base;
  bit       m_auto, m_enh, m_ackq, m_vld, m_irqn;
  int       m_src;
  bit [7:0] m_vec;

  always @(posedge clk) begin
    bit ack, start;
    bit [3:0] clr, act, np;
    int s;
    if (rst) begin
      m_pend = 0; m_mask = 0; m_clr = 0; m_base = 0; m_auto = 0; m_enh = 0;
      m_ackq = 0; m_vld = 0; m_irqn = 1; m_src = 0; m_vec = 0;
    end else begin
      ack   = !m1_n && !iorq_n;
      start = ack && !m_ackq;
      clr   = (reg_wr && reg_sel == 2'd2) ? reg_wdata[3:0] : 4'h0;
      if (start && m_auto && m_vld) clr[m_src] = 1'b1;
      act = m_pend & m_mask;
      np  = (m_pend & ~clr) | (req_in & m_mask);
      m_irqn = (act == 0);
      if (!ack) begin
        s = 0;
        for (int i = 3; i >= 0; i--) if (act[i]) s = i;
        m_vld = (act != 0);
        m_src = s;
        m_vec = m_enh ? {m_base, 3'(6 - 2 * s)} : 8'h00;
      end
      m_clr  = clr;
      m_ackq = ack;
      m_pend = np;
      if (reg_wr && reg_sel == 2'd0) begin
        m_base = reg_wdata[7:3]; m_auto = reg_wdata[0];
      end
      if (reg_wr && reg_sel == 2'd1) begin
        m_enh = reg_wdata[7]; m_mask = reg_wdata[3:0];
      end
    end
  end

  always @(posedge clk) begin
    #(CLK_P/4);
    if (!done) begin
      check("R2 irq_n vs model", irq_n, m_irqn);
      check("R6 clr_out vs model", clr_out, m_clr);
      check("R9 data_oe vs bus", data_oe, (!m1_n && !iorq_n));
      if (data_oe) check("R3 data_out vs model", data_out, m_vec);
    end
  end

  task automatic wr_reg(input [1:0] s, input [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; reg_sel = 2'd3;
  endtask

  task automatic pulse_req(input [3:0] r);
    @(negedge clk); req_in = r;
    @(negedge clk); req_in = 4'h0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_ack(output [7:0] b);
    @(negedge clk); m1_n = 1'b0; iorq_n = 1'b0;
    #1 b = data_out;
    @(negedge clk);
    @(negedge clk); m1_n = 1'b1; iorq_n = 1'b1;
  endtask

  initial begin
    logic [7:0] b;
    wait_n(3);
    rst = 1'b0;
    #1;
    check("R1 irq_n reset", irq_n, 1);
    check("R1 data_oe reset", data_oe, 0);
    check("R1 clr_out reset", clr_out, 0);

    wr_reg(2'd1, 8'h8F);
    wr_reg(2'd0, 8'h21);

    // R2/R3/R5: DMA channel 1 with base 0x20 -> 0x22
    pulse_req(4'b0100); wait_n(1);
    check("R2 irq asserted", irq_n, 0);
    do_ack(b);
    check("R3 dma1 vector", b, 8'h22);
    wait_n(1);
    check("R5 irq released after auto-clear", irq_n, 1);

    // R4: priority ordering
    pulse_req(4'b1010); pulse_req(4'b0001); wait_n(1);
    do_ack(b); check("R4 raster first", b, 8'h26); wait_n(1);
    do_ack(b); check("R4 dma0 second", b, 8'h24); wait_n(1);
    do_ack(b); check("R4 dma2 last", b, 8'h20); wait_n(1);
    check("R4 all serviced", irq_n, 1);

    // R12: raster arriving during acknowledge of a pending DMA request
    pulse_req(4'b0010); wait_n(1);
    @(negedge clk); m1_n = 1'b0; iorq_n = 1'b0; req_in = 4'b0001;
    #1 b = data_out;
    check("R12 dma vectored first", b, 8'h24);
    @(negedge clk); req_in = 4'h0;
    @(negedge clk); m1_n = 1'b1; iorq_n = 1'b1;
    wait_n(1);
    do_ack(b); check("R12 raster next", b, 8'h26); wait_n(1);

    // R6: auto-clear off
    wr_reg(2'd0, 8'h20);
    pulse_req(4'b1000); wait_n(1);
    do_ack(b); check("R6 dma2 vector", b, 8'h20); wait_n(1);
    check("R6 still pending", irq_n, 0);
    wr_reg(2'd2, 8'h08);
    check("R6 clear pulse", clr_out, 4'b1000);
    wait_n(1);
    check("R6 released by write", irq_n, 1);

    // R11: request in the same cycle as its auto-clear
    wr_reg(2'd0, 8'h21);
    pulse_req(4'b0001); wait_n(1);
    @(negedge clk); m1_n = 1'b0; iorq_n = 1'b0; req_in = 4'b0001;
    @(negedge clk); req_in = 4'h0;
    check("R11 clear pulse sent", clr_out, 4'b0001);
    @(negedge clk); m1_n = 1'b1; iorq_n = 1'b1;
    wait_n(2);
    check("R11 request survives", irq_n, 0);
    wr_reg(2'd2, 8'h01); wait_n(1);
    check("R11 cleared by write", irq_n, 1);

    // R9: opcode fetch and I/O cycles do not drive or service
    pulse_req(4'b0100); wait_n(1);
    @(negedge clk); m1_n = 1'b0;
    #1 check("R9 no drive on fetch", data_oe, 0);
    @(negedge clk); m1_n = 1'b1; iorq_n = 1'b0;
    #1 check("R9 no drive on io", data_oe, 0);
    @(negedge clk); iorq_n = 1'b1;
    wait_n(1);
    check("R9 not serviced", irq_n, 0);
    wr_reg(2'd2, 8'h04); wait_n(1);

    // R10: masked source ignored
    wr_reg(2'd1, 8'h81);
    pulse_req(4'b1000); wait_n(2);
    check("R10 masked no irq", irq_n, 1);
    wr_reg(2'd1, 8'h8F); wait_n(2);
    check("R10 not latched", irq_n, 1);

    // R7: enhanced off
    wr_reg(2'd1, 8'h0F);
    pulse_req(4'b0100); wait_n(1);
    do_ack(b); check("R7 zero byte", b, 8'h00); wait_n(1);

    // R8: all base bits set
    wr_reg(2'd1, 8'h8F);
    wr_reg(2'd0, 8'hFF);
    pulse_req(4'b0001); wait_n(1);
    do_ack(b);
    check("R8 top vector", b, 8'hFE);
    check("R8 never ff", (b == 8'hFF), 0);
    wait_n(2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule